// File: doc/BRIEF.md
# Trap entry and return controller

This block tracks whether a processor is running an interrupt handler, an exception handler, or both. It decides each cycle whether a trap is taken, and it keeps a separate saved instruction pointer and saved privilege value for the interrupt context and for the exception context. When a trap is taken, it captures the running code's IP and privilege register (PR) into the matching pair and commands PR to all ones. When the matching return instruction retires, it commands PR back to the saved value and redirects fetch to the saved IP.

Interrupt requests are level-sensitive. They wait while an interrupt handler or an exception handler is active. An exception raised inside an exception handler is reported as a double exception. In that case the saved exception state is left intact, so the outer exception can still return. The completion of a task-switch-and-exit operation ends all handler state without a return instruction. Vector lookup, fetch and the register file belong to neighbouring logic. The mode width is the parameter `XLEN`.

All outputs are registered. A request presented before clock edge k produces its outputs just after edge k.

Top module: `trap_ctrl`

## Requirements
- R1: While `rst_n` is low, `in_exc`, `in_irq`, `exc_take`, `irq_take`, `dbl_exc`, `redir_valid` and `pr_load` are all 0.
- R2: `exc_req` with `in_exc` = 0 takes an ordinary exception. In the next cycle `exc_take` = 1, `pr_load` = 1, `pr_value` is all ones and `in_exc` = 1. `cur_ip` and `cur_pr` are stored in the exception pair.
- R3: `irq_req` with `in_irq` = 0 and `in_exc` = 0, and no higher-priority event, takes an interrupt. In the next cycle `irq_take` = 1, `pr_load` = 1, `pr_value` is all ones and `in_irq` = 1. `cur_ip` and `cur_pr` are stored in the interrupt pair.
- R4: While `in_irq` = 1, `irq_req` is not accepted. The request stays pending, and it is taken in the cycle after `in_irq` drops if it is still high.
- R5: While `in_exc` = 1, no interrupt is accepted.
- R6: `exc_req` while `in_exc` = 1 gives `dbl_exc` = 1 for that one cycle, with `pr_load` = 1 and `pr_value` all ones. `in_exc` stays 1, and the saved exception IP and PR keep their values.
- R7: `ret_exc` while `in_exc` = 1, with no `exc_req`, gives `redir_valid` = 1. `redir_ip` is the saved exception IP, `pr_load` = 1, `pr_value` is the saved exception PR, and `in_exc` clears.
- R8: `ret_irq` while `in_irq` = 1, with no higher-priority event, gives `redir_valid` = 1. `redir_ip` is the saved interrupt IP, `pr_value` is the saved interrupt PR with `pr_load` = 1, and `in_irq` clears.
- R9: `tsx_done`, with no higher-priority event, clears both `in_exc` and `in_irq`. It raises neither `redir_valid` nor `pr_load`, and a pending interrupt is taken in the following cycle.
- R10: When `exc_req` and `irq_req` are both high in one cycle, the exception is taken and the interrupt stays pending until the exception ends.
- R11: A return whose handler flag is clear is ignored. `redir_valid` and `pr_load` stay 0 and the flags are unchanged.
- R12: The priority order is exception request, then exception return, then interrupt return, then task-switch-and-exit, then interrupt request. An exception request beats a return in the same cycle. An exception taken inside an interrupt handler is ordinary, and it leaves `in_irq` and the interrupt pair untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | Level interrupt request |
| exc_req | input | 1 | Exception raised this cycle |
| cur_ip | input | XLEN | IP of the running code |
| cur_pr | input | XLEN | PR of the running code |
| ret_exc | input | 1 | Exception return retired |
| ret_irq | input | 1 | Interrupt return retired |
| tsx_done | input | 1 | Task-switch-and-exit completed |
| redir_valid | output | 1 | Redirect fetch this cycle |
| redir_ip | output | XLEN | Redirect target |
| pr_load | output | 1 | Load PR this cycle |
| pr_value | output | XLEN | New PR value |
| exc_take | output | 1 | Ordinary exception taken |
| irq_take | output | 1 | Interrupt taken |
| dbl_exc | output | 1 | Double exception raised |
| in_exc | output | 1 | Exception handler active |
| in_irq | output | 1 | Interrupt handler active |

## Verification
The hardest state to reach is the one where an exception handler runs inside an interrupt handler. In that state both saved pairs must hold different values at once, a double exception must not disturb the outer exception state, and the two returns must unwind in order. The stimulus builds this state on purpose. It takes an exception while an interrupt request is held high, provokes a double exception together with a competing return, and then returns. It lets the pending interrupt enter, takes a second exception inside it, and unwinds both levels. The sweep repeats this sequence for sixteen arithmetic IP and PR patterns. Because the IP and PR values differ at every level, a return that reads the wrong pair shows up.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [2:0] {
      EV_NONE    = 3'd0,
      EV_EXC     = 3'd1,
      EV_DBL     = 3'd2,
      EV_RET_EXC = 3'd3,
      EV_RET_IRQ = 3'd4,
      EV_TSX     = 3'd5,
      EV_IRQ     = 3'd6
   } trap_ev_e;

   localparam int CTX_EXC = 0;
   localparam int CTX_IRQ = 1;
   localparam int NUM_CTX = 2;
endpackage

// File: rtl/trap_arb.sv
module trap_arb
   import trap_pkg::*;
(
   input  logic     exc_req,
   input  logic     irq_req,
   input  logic     ret_exc,
   input  logic     ret_irq,
   input  logic     tsx_done,
   input  logic     in_exc,
   input  logic     in_irq,
   output trap_ev_e ev
);
   always_comb begin
      ev = EV_NONE;
      if (exc_req)
         ev = in_exc ? EV_DBL : EV_EXC;
      else if (ret_exc && in_exc)
         ev = EV_RET_EXC;
      else if (ret_irq && in_irq)
         ev = EV_RET_IRQ;
      else if (tsx_done)
         ev = EV_TSX;
      else if (irq_req && !in_irq && !in_exc)
         ev = EV_IRQ;
   end
endmodule

// File: rtl/trap_ctx_pair.sv
module trap_ctx_pair #(
   parameter int XLEN = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            capture,
   input  logic [XLEN-1:0] ip_in,
   input  logic [XLEN-1:0] pr_in,
   output logic [XLEN-1:0] ip_q,
   output logic [XLEN-1:0] pr_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ip_q <= '0;
         pr_q <= '0;
      end else if (capture) begin
         ip_q <= ip_in;
         pr_q <= pr_in;
      end
   end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
   import trap_pkg::*;
#(
   parameter int XLEN = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            irq_req,
   input  logic            exc_req,
   input  logic [XLEN-1:0] cur_ip,
   input  logic [XLEN-1:0] cur_pr,
   input  logic            ret_exc,
   input  logic            ret_irq,
   input  logic            tsx_done,
   output logic            redir_valid,
   output logic [XLEN-1:0] redir_ip,
   output logic            pr_load,
   output logic [XLEN-1:0] pr_value,
   output logic            exc_take,
   output logic            irq_take,
   output logic            dbl_exc,
   output logic            in_exc,
   output logic            in_irq
);
   localparam logic [XLEN-1:0] PR_ALL = {XLEN{1'b1}};

   if (XLEN < 4 || (XLEN % 2) != 0) begin : g_bad_xlen
      $error("trap_ctrl: XLEN must be even and at least 4");
   end

   trap_ev_e ev;

   trap_arb u_arb (
      .exc_req (exc_req),
      .irq_req (irq_req),
      .ret_exc (ret_exc),
      .ret_irq (ret_irq),
      .tsx_done(tsx_done),
      .in_exc  (in_exc),
      .in_irq  (in_irq),
      .ev      (ev)
   );

   logic [NUM_CTX-1:0]  cap;
   logic [XLEN-1:0]     sv_ip [NUM_CTX];
   logic [XLEN-1:0]     sv_pr [NUM_CTX];

   assign cap[CTX_EXC] = (ev == EV_EXC);
   assign cap[CTX_IRQ] = (ev == EV_IRQ);

   for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
      trap_ctx_pair #(.XLEN(XLEN)) u_pair (
         .clk    (clk),
         .rst_n  (rst_n),
         .capture(cap[g]),
         .ip_in  (cur_ip),
         .pr_in  (cur_pr),
         .ip_q   (sv_ip[g]),
         .pr_q   (sv_pr[g])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_exc      <= 1'b0;
         in_irq      <= 1'b0;
         exc_take    <= 1'b0;
         irq_take    <= 1'b0;
         dbl_exc     <= 1'b0;
         redir_valid <= 1'b0;
         pr_load     <= 1'b0;
         redir_ip    <= '0;
         pr_value    <= '0;
      end else begin
         exc_take    <= (ev == EV_EXC);
         irq_take    <= (ev == EV_IRQ);
         dbl_exc     <= (ev == EV_DBL);
         redir_valid <= (ev == EV_RET_EXC) || (ev == EV_RET_IRQ);
         pr_load     <= (ev != EV_NONE) && (ev != EV_TSX);
         case (ev)
            EV_EXC: begin
               in_exc   <= 1'b1;
               pr_value <= PR_ALL;
            end
            EV_DBL: pr_value <= PR_ALL;
            EV_IRQ: begin
               in_irq   <= 1'b1;
               pr_value <= PR_ALL;
            end
            EV_RET_EXC: begin
               in_exc   <= 1'b0;
               pr_value <= sv_pr[CTX_EXC];
               redir_ip <= sv_ip[CTX_EXC];
            end
            EV_RET_IRQ: begin
               in_irq   <= 1'b0;
               pr_value <= sv_pr[CTX_IRQ];
               redir_ip <= sv_ip[CTX_IRQ];
            end
            EV_TSX: begin
               in_exc <= 1'b0;
               in_irq <= 1'b0;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
   parameter int XLEN = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_req,
   input logic            exc_req,
   input logic            ret_exc,
   input logic            ret_irq,
   input logic            tsx_done,
   input logic            redir_valid,
   input logic            pr_load,
   input logic [XLEN-1:0] pr_value,
   input logic            exc_take,
   input logic            irq_take,
   input logic            dbl_exc,
   input logic            in_exc,
   input logic            in_irq
);
   assert_one_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({exc_take, irq_take, dbl_exc, redir_valid}));

   assert_exc_sets_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && !in_exc |=> exc_take && in_exc);

   assert_irq_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> !$past(in_irq));

   assert_irq_held_by_exc_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |-> !$past(in_exc));

   assert_dbl_on_nested_exc_R6: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req && in_exc |=> dbl_exc && in_exc);

   assert_dbl_forces_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dbl_exc |-> pr_load && (pr_value == {XLEN{1'b1}}));

   assert_ret_exc_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ret_exc && in_exc && !exc_req |=> redir_valid && !in_exc);

   assert_tsx_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tsx_done && !exc_req && !(ret_exc && in_exc) && !(ret_irq && in_irq)
      |=> !in_exc && !in_irq && !pr_load);
endmodule

bind trap_ctrl trap_ctrl_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/trap_ctrl_test.sv
`timescale 1ns/1ps
module trap_ctrl_test;
   localparam int W = 8;
   localparam logic [W-1:0] ONES = {W{1'b1}};

   logic clk = 1'b0;
   logic rst_n;
   logic irq_req, exc_req, ret_exc, ret_irq, tsx_done;
   logic [W-1:0] cur_ip, cur_pr;
   logic redir_valid, pr_load, exc_take, irq_take, dbl_exc, in_exc, in_irq;
   logic [W-1:0] redir_ip, pr_value;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   trap_ctrl #(.XLEN(W)) uut (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick(input logic e, input logic q, input logic re, input logic ri,
                       input logic ts, input logic [W-1:0] ip, input logic [W-1:0] pr);
      @(negedge clk);
      exc_req = e; irq_req = q; ret_exc = re; ret_irq = ri; tsx_done = ts;
      cur_ip = ip; cur_pr = pr;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      tick(0, 0, 0, 0, 0, 0, 0);
      tick(1, 1, 0, 0, 0, 8'h11, 8'h22);
      chk("R1 flags", {30'd0, in_exc, in_irq}, 0);
      chk("R1 pulses", {27'd0, exc_take, irq_take, dbl_exc, redir_valid, pr_load}, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 16; i++) begin
         logic [W-1:0] a, b, c, d, a2, b2;
         a = W'(i * 17 + 3); b = W'(i * 29 + 5);
         c = W'(i * 13 + 100); d = W'(i * 7 + 60);
         a2 = a ^ 8'hF0; b2 = b ^ 8'h0F;
         // R2, R10: exception wins over a simultaneous interrupt
         tick(1, 1, 0, 0, 0, a, b);
         chk("R2 exc_take", exc_take, 1);
         chk("R2 pr ones", {pr_load, pr_value}, {1'b1, ONES});
         chk("R10 irq held", {irq_take, in_irq, in_exc}, 3'b001);
         // R5: interrupt blocked in exception handler
         tick(0, 1, 0, 0, 0, c, d);
         chk("R5 blocked", {irq_take, in_irq}, 0);
         // R6, R12: nested exception beats a return, becomes double
         tick(1, 1, 1, 0, 0, c, d);
         chk("R6 dbl", {dbl_exc, exc_take, redir_valid, in_exc}, 4'b1001);
         chk("R6 pr ones", {pr_load, pr_value}, {1'b1, ONES});
         tick(0, 1, 0, 0, 0, c, d);
         chk("R6 one cycle", dbl_exc, 0);
         // R11: interrupt return with no interrupt active
         tick(0, 1, 0, 1, 0, c, d);
         chk("R11 ignored", {redir_valid, pr_load, irq_take, in_exc, in_irq}, 5'b00010);
         // R7, R6: return restores the first exception's state
         tick(0, 1, 1, 0, 0, c, d);
         chk("R7 redirect", {redir_valid, redir_ip}, {1'b1, a});
         chk("R7 pr restore", {pr_load, pr_value}, {1'b1, b});
         chk("R7 flag", {in_exc, irq_take}, 0);
         // R3, R10: pending interrupt taken after exception ends
         tick(0, 1, 0, 0, 0, c, d);
         chk("R3 irq_take", {irq_take, in_irq, pr_load, pr_value}, {3'b111, ONES});
         // R4: no second interrupt
         tick(0, 1, 0, 0, 0, a, b);
         chk("R4 blocked", irq_take, 0);
         // R12: ordinary exception inside interrupt handler
         tick(1, 1, 0, 0, 0, a2, b2);
         chk("R12 nested exc", {exc_take, dbl_exc, in_exc, in_irq}, 4'b1011);
         tick(0, 0, 1, 0, 0, 0, 0);
         chk("R12 inner ret", {redir_valid, redir_ip, pr_value}, {1'b1, a2, b2});
         chk("R12 irq kept", {in_exc, in_irq}, 2'b01);
         // R8: interrupt return
         tick(0, 0, 0, 1, 0, 0, 0);
         chk("R8 redirect", {redir_valid, redir_ip, pr_load, pr_value}, {1'b1, c, 1'b1, d});
         chk("R8 flag", in_irq, 0);
         // R11: exception return with no exception active
         tick(0, 0, 1, 0, 0, 0, 0);
         chk("R11 ignored exc", {redir_valid, pr_load, in_exc, in_irq}, 0);
         // R9: task-switch-and-exit clears both levels
         tick(0, 1, 0, 0, 0, a, b);
         tick(1, 0, 0, 0, 0, c, d);
         chk("R9 setup", {in_exc, in_irq}, 2'b11);
         tick(0, 1, 0, 0, 1, 0, 0);
         chk("R9 clear", {in_exc, in_irq, redir_valid, pr_load, irq_take}, 0);
         tick(0, 1, 0, 0, 0, a, b);
         chk("R9 irq after", {irq_take, in_irq}, 2'b11);
         tick(0, 0, 0, 0, 1, 0, 0);
         chk("R9 clear irq", in_irq, 0);
      end
      // R1: reset while handlers active
      tick(1, 0, 0, 0, 0, 1, 2);
      @(negedge clk); rst_n = 1'b0; exc_req = 0;
      @(posedge clk); #1;
      chk("R1 mid reset", {in_exc, in_irq, exc_take, pr_load, redir_valid}, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule